// File: doc/BRIEF.md
# SONET Transmit Pointer Generator

This block produces the payload pointer for an outgoing STS-1 frame. It times the frame from a free-running row/column slot counter, which a frame-start pulse can resynchronise. It keeps the current payload offset and builds the 16-bit pointer word from it. On each byte slot it also says whether a payload byte must be read from the elastic store. Three sources can change the offset:
- an increment or decrement request from the receive-side interpreter;
- a J1 marker on a payload byte that turns up where the stored offset does not predict it;
- an indication that the interpreter is leaving alarm (AIS) state.

Justification requests are sampled once per frame, on one overhead slot. That slot is the F1 position (row 1, column 2) or the E2 position (row 8, column 2). The choice is made once, when relative frame alignment is declared, and holds until alignment is dropped. One action is chosen at the H1 slot of each frame and holds for the whole frame. The pointer word changes at H1. The offset changes at the H3 slot, so that the bytes after H3 follow the new value.

Slot numbering counts rows 0 to 8 and columns 0 to 89 within the frame. The H1, H2 and H3 bytes sit in row 3 at columns 0, 1 and 2. Payload position 0 is the slot just after H3.

Top module: `sonet_ptr_gen`

## Requirements
- R1: After reset the offset is 0 and the pointer word is 0x6000: flag nibble 0110, size bits 00, pointer field 0.
- R2: Requests are sampled only on the selected slot. The F1 slot is selected when `e2_pick` is 0, and the E2 slot when it is 1, as captured on the cycle `align_valid` rises. A request on any other slot has no effect, and the latched requests read as clear while `align_valid` is low.
- R3: A decrement frame carries the old offset with word bits [8],[6],[4],[2],[0] inverted, for that frame only. In that frame `pay_rd_en` and `h3_sel` are high on the H3 slot, and the offset drops by one from the H3 slot on.
- R4: An increment frame carries the old offset with word bits [9],[7],[5],[3],[1] inverted, for that frame only. In that frame `pay_rd_en` is low on the slot after H3, and the offset rises by one from the H3 slot on.
- R5: After any frame whose pointer changes (justification or new data flag), at least three frames with a plain pointer word pass before the next justification. Requests that arrive earlier are dropped.
- R6: A pending new data flag wins over a justification, and a decrement wins over an increment.
- R7: A J1 marker on a read payload byte whose position differs from the offset causes, at the next H1, a word with flag nibble 1001 and that position in the pointer field. The offset takes that value at the H3 slot. A marker at the expected position has no effect.
- R8: A pulse on `ais_exit` causes the next frame to carry flag nibble 1001 with the offset unchanged.
- R9: The flag nibble is 1001 for exactly one frame per event and 0110 otherwise. The size bits are always 00.
- R10: The offset stays below 783 and wraps: decrementing 0 gives 782 and incrementing 782 gives 0.
- R11: `pay_rd_en` is high on every slot of columns 3 to 89, apart from the R4 exception. It is low on columns 0 to 2, apart from the R3 exception. `h3_sel` is low (fixed zero filler) outside a decrement frame's H3 slot.
- R12: The pointer word changes only in the cycle after an H1 slot, and the offset only in the cycle after an H3 slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks the current slot as row 0, column 0 |
| align_valid | input | 1 | Relative frame alignment established |
| e2_pick | input | 1 | Latch on the E2 slot (1) or the F1 slot (0); captured on the rise of align_valid |
| inc_req | input | 1 | Increment request from the interpreter |
| dec_req | input | 1 | Decrement request from the interpreter |
| ais_exit | input | 1 | Pulse: the interpreter is leaving AIS state |
| j1_mark | input | 1 | The byte being read from the elastic store is marked J1 |
| ptr_word | output | 16 | Outgoing H1 (bits 15:8) and H2 (bits 7:0) content |
| offset | output | 10 | Current payload offset |
| h3_sel | output | 1 | H3 carries payload (1) or zero filler (0) |
| pay_rd_en | output | 1 | Read one payload byte from the elastic store on this slot |

## Verification
The assertions assume that `frame_start`, when present, arrives on whole-frame boundaries. They also assume that `j1_mark` occurs at most once per frame and only together with a read. The stimulus pulses `frame_start` every 810 cycles. It places requests on one slot of the frame only, and puts a J1 marker only on a payload slot whose position is computed from the row and column. Alignment is dropped only on the first slot of a frame, so the new selection takes effect before either latch slot.

// File: rtl/pg_pkg.sv
package pg_pkg;

  localparam int PTR_W = 10;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2,
    ACT_NDF  = 2'd3
  } act_e;

  localparam logic [3:0] FLAG_SET  = 4'b1001;
  localparam logic [3:0] FLAG_IDLE = 4'b0110;
  localparam logic [1:0] SIZE_BITS = 2'b00;

  // Increment-marking bits sit on odd indices of the pointer field.
  function automatic logic [PTR_W-1:0] inc_bits();
    logic [PTR_W-1:0] m;
    for (int i = 0; i < PTR_W; i++) m[i] = (i % 2 == 1);
    return m;
  endfunction

  function automatic logic [PTR_W-1:0] dec_bits();
    return ~inc_bits();
  endfunction

endpackage

// File: rtl/pg_frame_timer.sv
module pg_frame_timer
  import pg_pkg::*;
#(
  parameter int ROWS     = 9,
  parameter int COLS     = 90,
  parameter int TOH_COLS = 3,
  parameter int H_ROW    = 3,
  parameter int F1_ROW   = 1,
  parameter int E2_ROW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  output logic             is_h1,
  output logic             is_h3,
  output logic             is_stuff,
  output logic             is_spe,
  output logic             is_f1,
  output logic             is_e2,
  output logic [PTR_W-1:0] pos
);

  localparam int RW        = $clog2(ROWS);
  localparam int CW        = $clog2(COLS);
  localparam int SPE_BYTES = (COLS - TOH_COLS) * ROWS;

  localparam logic [RW-1:0]    ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0]    COL_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0]    ROW_H    = RW'(H_ROW);
  localparam logic [RW-1:0]    ROW_F1   = RW'(F1_ROW);
  localparam logic [RW-1:0]    ROW_E2   = RW'(E2_ROW);
  localparam logic [CW-1:0]    COL_OH   = CW'(TOH_COLS - 1);
  localparam logic [CW-1:0]    COL_SPE  = CW'(TOH_COLS);
  localparam logic [PTR_W-1:0] POS_LAST = PTR_W'(SPE_BYTES - 1);

  logic [RW-1:0]    row_q, row_d, cur_row;
  logic [CW-1:0]    col_q, col_d, cur_col;
  logic [PTR_W-1:0] pos_q, pos_d;

  always_comb begin
    cur_row = frame_start ? '0 : row_q;
    cur_col = frame_start ? '0 : col_q;
    row_d   = cur_row;
    col_d   = cur_col + 1'b1;
    if (cur_col == COL_LAST) begin
      col_d = '0;
      row_d = (cur_row == ROW_LAST) ? '0 : cur_row + 1'b1;
    end
  end

  always_comb begin
    is_h1    = (cur_row == ROW_H)  && (cur_col == '0);
    is_h3    = (cur_row == ROW_H)  && (cur_col == COL_OH);
    is_stuff = (cur_row == ROW_H)  && (cur_col == COL_SPE);
    is_f1    = (cur_row == ROW_F1) && (cur_col == COL_OH);
    is_e2    = (cur_row == ROW_E2) && (cur_col == COL_OH);
    is_spe   = (cur_col >= COL_SPE);
  end

  // Payload position: H3 slot counts as the slot just before position 0.
  always_comb begin
    pos   = is_h3 ? POS_LAST : pos_q;
    pos_d = pos_q;
    if (is_h3)       pos_d = '0;
    else if (is_spe) pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      pos_q <= '0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
      pos_q <= pos_d;
    end
  end

  p_pos_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_LAST);

  p_slot_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_h1, is_h3, is_f1, is_e2, is_spe}));

endmodule

// File: rtl/pg_just_latch.sv
module pg_just_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic align_valid,
  input  logic e2_pick,
  input  logic is_f1,
  input  logic is_e2,
  input  logic inc_req,
  input  logic dec_req,
  output logic inc_l,
  output logic dec_l
);

  logic align_q;
  logic sel_e2_q, sel_e2_d, sel_now;
  logic latch_now;
  logic inc_d, dec_d;

  always_comb begin
    sel_now   = (align_valid && !align_q) ? e2_pick : sel_e2_q;
    sel_e2_d  = sel_now;
    latch_now = align_valid && (sel_now ? is_e2 : is_f1);
    inc_d     = inc_l;
    dec_d     = dec_l;
    if (!align_valid) begin
      inc_d = 1'b0;
      dec_d = 1'b0;
    end else if (latch_now) begin
      inc_d = inc_req;
      dec_d = dec_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_q  <= 1'b0;
      sel_e2_q <= 1'b0;
      inc_l    <= 1'b0;
      dec_l    <= 1'b0;
    end else begin
      align_q  <= align_valid;
      sel_e2_q <= sel_e2_d;
      inc_l    <= inc_d;
      dec_l    <= dec_d;
    end
  end

  p_inc_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_f1 || is_e2) |=> !$rose(inc_l));

  p_dec_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_f1 || is_e2) |=> !$rose(dec_l));

endmodule

// File: rtl/pg_ptr_ctrl.sv
module pg_ptr_ctrl
  import pg_pkg::*;
#(
  parameter int SPE_BYTES    = 783,
  parameter int HOLDOFF      = 3,
  parameter int RESET_OFFSET = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_h1,
  input  logic             is_h3,
  input  logic             is_stuff,
  input  logic             is_spe,
  input  logic [PTR_W-1:0] pos,
  input  logic             j1_mark,
  input  logic             ais_exit,
  input  logic             inc_l,
  input  logic             dec_l,
  output logic [15:0]      ptr_word,
  output logic [PTR_W-1:0] offset,
  output logic             h3_sel,
  output logic             rd_en
);

  localparam int HW = $clog2(HOLDOFF + 1);
  localparam logic [HW-1:0]    HOLD_FULL = HW'(HOLDOFF);
  localparam logic [PTR_W-1:0] OFF_LAST  = PTR_W'(SPE_BYTES - 1);
  localparam logic [PTR_W-1:0] OFF_INIT  = PTR_W'(RESET_OFFSET);
  localparam logic [PTR_W-1:0] M_INC     = inc_bits();
  localparam logic [PTR_W-1:0] M_DEC     = dec_bits();

  act_e             act_q, act_d;
  logic [HW-1:0]    hold_q, hold_d;
  logic             pend_q, pend_d;
  logic [PTR_W-1:0] nval_q, nval_d;
  logic [PTR_W-1:0] off_d;
  logic [15:0]      word_d;
  logic             j1_miss;
  logic             just_ok;

  // Read enable and H3 content select for the current slot.
  always_comb begin
    rd_en  = (is_spe && !(is_stuff && act_q == ACT_INC)) ||
             (is_h3 && act_q == ACT_DEC);
    h3_sel = is_h3 && (act_q == ACT_DEC);
  end

  // New data flag bookkeeping: J1 mismatch or AIS exit.
  always_comb begin
    j1_miss = j1_mark && rd_en && (pos != offset);
    nval_d  = nval_q;
    if (j1_miss)                  nval_d = pos;
    else if (ais_exit && !pend_q) nval_d = offset;
    pend_d = pend_q;
    if (is_h1)               pend_d = 1'b0;
    if (j1_miss || ais_exit) pend_d = 1'b1;
  end

  // Frame action, chosen at H1.
  always_comb begin
    just_ok = (hold_q == HOLD_FULL);
    if (pend_q)                act_d = ACT_NDF;
    else if (just_ok && dec_l) act_d = ACT_DEC;
    else if (just_ok && inc_l) act_d = ACT_INC;
    else                       act_d = ACT_NONE;

    case (act_d)
      ACT_INC: word_d = {FLAG_IDLE, SIZE_BITS, offset ^ M_INC};
      ACT_DEC: word_d = {FLAG_IDLE, SIZE_BITS, offset ^ M_DEC};
      ACT_NDF: word_d = {FLAG_SET,  SIZE_BITS, nval_q};
      default: word_d = {FLAG_IDLE, SIZE_BITS, offset};
    endcase

    hold_d = hold_q;
    if (act_d != ACT_NONE)       hold_d = '0;
    else if (hold_q < HOLD_FULL) hold_d = hold_q + 1'b1;
  end

  // Offset update, applied at H3.
  always_comb begin
    case (act_q)
      ACT_INC: off_d = (offset == OFF_LAST) ? '0 : offset + 1'b1;
      ACT_DEC: off_d = (offset == '0) ? OFF_LAST : offset - 1'b1;
      ACT_NDF: off_d = nval_q;
      default: off_d = offset;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= ACT_NONE;
      hold_q   <= HOLD_FULL;
      ptr_word <= {FLAG_IDLE, SIZE_BITS, OFF_INIT};
    end else if (is_h1) begin
      act_q    <= act_d;
      hold_q   <= hold_d;
      ptr_word <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) offset <= OFF_INIT;
    else if (is_h3) offset <= off_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      nval_q <= '0;
    end else begin
      pend_q <= pend_d;
      nval_q <= nval_d;
    end
  end

  p_word_at_h1_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !is_h1 |=> $stable(ptr_word));

  p_off_at_h3_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !is_h3 |=> $stable(offset));

  p_flag_nibble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_word[15:12] == FLAG_IDLE || ptr_word[15:12] == FLAG_SET) &&
    ptr_word[11:10] == SIZE_BITS);

  p_offset_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    offset <= OFF_LAST);

  p_stuff_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stuff && !rd_en) |-> !h3_sel);

endmodule

// File: rtl/sonet_ptr_gen.sv
module sonet_ptr_gen
  import pg_pkg::*;
#(
  parameter int ROWS         = 9,
  parameter int COLS         = 90,
  parameter int TOH_COLS     = 3,
  parameter int H_ROW        = 3,
  parameter int F1_ROW       = 1,
  parameter int E2_ROW       = 8,
  parameter int HOLDOFF      = 3,
  parameter int RESET_OFFSET = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  input  logic        align_valid,
  input  logic        e2_pick,
  input  logic        inc_req,
  input  logic        dec_req,
  input  logic        ais_exit,
  input  logic        j1_mark,
  output logic [15:0] ptr_word,
  output logic [9:0]  offset,
  output logic        h3_sel,
  output logic        pay_rd_en
);

  localparam int SPE_BYTES = (COLS - TOH_COLS) * ROWS;

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             is_h1, is_h3, is_stuff, is_spe, is_f1, is_e2;
  logic [PTR_W-1:0] pos;
  logic             inc_l, dec_l;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  pg_frame_timer #(
    .ROWS(ROWS), .COLS(COLS), .TOH_COLS(TOH_COLS),
    .H_ROW(H_ROW), .F1_ROW(F1_ROW), .E2_ROW(E2_ROW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n_s), .frame_start(frame_start),
    .is_h1(is_h1), .is_h3(is_h3), .is_stuff(is_stuff), .is_spe(is_spe),
    .is_f1(is_f1), .is_e2(is_e2), .pos(pos)
  );

  pg_just_latch u_latch (
    .clk(clk), .rst_n(rst_n_s), .align_valid(align_valid), .e2_pick(e2_pick),
    .is_f1(is_f1), .is_e2(is_e2), .inc_req(inc_req), .dec_req(dec_req),
    .inc_l(inc_l), .dec_l(dec_l)
  );

  pg_ptr_ctrl #(
    .SPE_BYTES(SPE_BYTES), .HOLDOFF(HOLDOFF), .RESET_OFFSET(RESET_OFFSET)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .is_h1(is_h1), .is_h3(is_h3),
    .is_stuff(is_stuff), .is_spe(is_spe), .pos(pos), .j1_mark(j1_mark),
    .ais_exit(ais_exit), .inc_l(inc_l), .dec_l(dec_l),
    .ptr_word(ptr_word), .offset(offset), .h3_sel(h3_sel), .rd_en(pay_rd_en)
  );

  p_h3sel_reads_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    h3_sel |-> pay_rd_en);

endmodule

// File: tb/sim_sonet_ptr_gen.sv
module sim_sonet_ptr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 810;
  localparam int S_F1 = 92, S_E2 = 722, S_AIS = 100;
  localparam int S_H1 = 270, S_H3 = 272, S_STUFF = 273, S_SAMPLE = 400;
  localparam int NVEC = 20;

  // {inc, dec, ais, kind[1:0], word[15:0], offset[9:0]}; kind 0 plain, 1 inc, 2 dec, 3 flag
  localparam logic [30:0] VEC [NVEC] = '{
    {3'b000, 2'd0, 16'h6000, 10'd0},
    {3'b100, 2'd1, 16'h62AA, 10'd1},
    {3'b100, 2'd0, 16'h6001, 10'd1},
    {3'b100, 2'd0, 16'h6001, 10'd1},
    {3'b100, 2'd0, 16'h6001, 10'd1},
    {3'b010, 2'd2, 16'h6154, 10'd0},
    {3'b010, 2'd0, 16'h6000, 10'd0},
    {3'b000, 2'd0, 16'h6000, 10'd0},
    {3'b000, 2'd0, 16'h6000, 10'd0},
    {3'b010, 2'd2, 16'h6155, 10'd782},
    {3'b000, 2'd0, 16'h630E, 10'd782},
    {3'b001, 2'd3, 16'h930E, 10'd782},
    {3'b000, 2'd0, 16'h630E, 10'd782},
    {3'b000, 2'd0, 16'h630E, 10'd782},
    {3'b000, 2'd0, 16'h630E, 10'd782},
    {3'b100, 2'd1, 16'h61A4, 10'd0},
    {3'b100, 2'd0, 16'h6000, 10'd0},
    {3'b000, 2'd0, 16'h6000, 10'd0},
    {3'b000, 2'd0, 16'h6000, 10'd0},
    {3'b110, 2'd2, 16'h6155, 10'd782}
  };

  logic clk = 1'b0;
  logic rst_n, frame_start, align_valid, e2_pick;
  logic inc_req, dec_req, ais_exit, j1_mark;
  logic [15:0] ptr_word;
  logic [9:0]  offset;
  logic h3_sel, pay_rd_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] s_word;
  logic [9:0]  s_off;
  logic s_h1_rd, s_h3_rd, s_h3_sel, s_stuff_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sonet_ptr_gen u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .align_valid(align_valid), .e2_pick(e2_pick), .inc_req(inc_req),
    .dec_req(dec_req), .ais_exit(ais_exit), .j1_mark(j1_mark),
    .ptr_word(ptr_word), .offset(offset), .h3_sel(h3_sel), .pay_rd_en(pay_rd_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One frame of stimulus; samples land mid-cycle after inputs settle.
  task automatic run_frame(input bit inc_f1, input bit dec_f1, input bit inc_e2,
                           input bit ais, input int j1_slot, input bit realign);
    for (int s = 0; s < FRAME; s++) begin
      @(negedge clk);
      frame_start = (s == 0);
      inc_req     = (inc_f1 && s == S_F1) || (inc_e2 && s == S_E2);
      dec_req     = dec_f1 && s == S_F1;
      ais_exit    = ais && s == S_AIS;
      j1_mark     = (s == j1_slot);
      if (realign) align_valid = (s != 0);
      #1;
      if (s == S_H1)     s_h1_rd    = pay_rd_en;
      if (s == S_H3)     begin s_h3_rd = pay_rd_en; s_h3_sel = h3_sel; end
      if (s == S_STUFF)  s_stuff_rd = pay_rd_en;
      if (s == S_SAMPLE) begin s_word = ptr_word; s_off = offset; end
    end
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; align_valid = 1'b1; e2_pick = 1'b0;
    inc_req = 1'b0; dec_req = 1'b0; ais_exit = 1'b0; j1_mark = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(ptr_word == 16'h6000, "R1 reset word", ptr_word, 16'h6000);
    check(offset == 10'd0, "R1 reset offset", offset, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Table walk: R3 R4 R5 R6 R8 R9 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] kind;
      kind = VEC[i][27:26];
      run_frame(VEC[i][30], VEC[i][29], 1'b0, VEC[i][28], -1, 1'b0);
      check(s_word == VEC[i][25:10], "R3/R4/R5/R6/R8/R9 word", s_word, VEC[i][25:10]);
      check(s_off == VEC[i][9:0], "R10 offset", s_off, VEC[i][9:0]);
      check(s_stuff_rd == (kind != 2'd1), "R4 stuff slot read", s_stuff_rd, kind != 2'd1);
      check(s_h3_rd == (kind == 2'd2), "R3 H3 read", s_h3_rd, kind == 2'd2);
      check(s_h3_sel == (kind == 2'd2), "R11 H3 select", s_h3_sel, kind == 2'd2);
      check(s_h1_rd == 1'b0, "R11 no read on H1", s_h1_rd, 0);
    end

    // R7: J1 at payload position 100 (row 4, column 16) while offset is 782
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, 376, 1'b0);
    check(s_word == 16'h630E, "R7 word before flag", s_word, 16'h630E);
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    check(s_word == 16'h9064, "R7 flag word", s_word, 16'h9064);
    check(s_off == 10'd100, "R7 offset loaded", s_off, 100);
    // R7: J1 at the expected position is ignored
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, 376, 1'b0);
    check(s_word == 16'h6064, "R9 flag one frame", s_word, 16'h6064);
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    check(s_word == 16'h6064, "R7 matching J1 ignored", s_word, 16'h6064);
    check(s_off == 10'd100, "R7 offset kept", s_off, 100);

    // R2: realign selecting E2; an F1 request is ignored, an E2 request taken
    e2_pick = 1'b1;
    run_frame(1'b1, 1'b0, 1'b1, 1'b0, -1, 1'b1);
    check(s_word == 16'h6064, "R2 F1 request ignored", s_word, 16'h6064);
    check(s_off == 10'd100, "R2 offset unchanged", s_off, 100);
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    check(s_word == 16'h62CE, "R2 E2 request applied", s_word, 16'h62CE);
    check(s_off == 10'd101, "R2 offset after E2 inc", s_off, 101);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule